// File: doc/BRIEF.md
# Byte-Synchronous Character Receiver

This block receives a character-oriented synchronous serial line. Each received bit arrives with a one-cycle bit strobe taken from an external line clock. Before it has character alignment, the receiver is in hunt mode and looks for a programmable SYN pattern. It can align in three ways: on one SYN match, on two SYN characters back to back, or on an external sync pulse. Once aligned, it cuts the bit stream into 8-bit characters. SYN fill characters are dropped. Every other character is sent on an output stream and is also fed to a CRC register.

The CRC register can use either of two generator polynomials, and its starting value can be all zeros or all ones. It is a plain error check: the register is compared with zero, so a block of data followed by its own CRC leaves the register at zero. Output characters are held in a single register. If a character completes while that register is still waiting for the consumer, the new character is lost and a sticky overrun flag is raised. A host command returns the receiver to hunt mode, reloads the CRC starting value and clears the overrun flag.

Output stream rules: `out_valid` stays high, with `out_data` unchanged, until a cycle in which `out_ready` is high. The transfer happens in that cycle. Back-pressure does not slow the line, because the line cannot be stalled. Instead, holding `out_ready` low for longer than one character time causes an overrun.

Top module: `bsync_rx`

## Requirements
- R1: With `cfg_mode`=0 (single-SYN mode), the receiver in hunt mode compares the last 8 received bits with `cfg_syn` after every bit strobe. On the first match, `sync_ok` goes high in the next cycle. The matched SYN character is not output.
- R2: With `cfg_mode`=1 (double-SYN mode), a SYN match is followed by the next 8 bits as one character. Alignment is declared only if that character also equals `cfg_syn`. Otherwise the receiver goes back to bit-by-bit hunting, and `sync_ok` stays low.
- R3: With `cfg_mode`=2 or 3 (external mode), `cfg_syn` is not used for alignment. Instead, a bit strobe with `ext_sync` high declares alignment; the value of that bit is discarded. The next 8 bits form the first character.
- R4: Once aligned, each group of 8 bit strobes forms one character. The first bit received is the most significant bit (bit 7).
- R5: A character equal to `cfg_syn` that arrives after alignment is deleted. It does not appear on the output and does not change the CRC.
- R6: `out_valid` stays high, with `out_data` stable, until it is accepted by `out_ready`. Each non-SYN character is presented exactly once, in the order received.
- R7: If a non-SYN character completes while `out_valid` is high and `out_ready` is low, that character is dropped and `overrun` goes high. `overrun` stays high until `cmd_hunt` clears it.
- R8: `cfg_crc_sel`=0 selects the polynomial x^16+x^15+x^2+1 (0x8005). `cfg_crc_sel`=1 selects x^16+x^12+x^5+1 (0x1021). The CRC is processed MSB first, is not reflected and has no final XOR. `crc_err` is high whenever the CRC register is not zero, so data followed by its CRC (high byte first) gives `crc_err`=0.
- R9: The CRC register is loaded with 0x0000 when `cfg_crc_ones`=0 and with 0xFFFF when it is 1. This happens at reset and on `cmd_hunt`.
- R10: `cmd_hunt` puts the receiver back in hunt mode, so `sync_ok` is low in the next cycle. It also reloads the CRC and clears `overrun`. It does not touch a character already held on the output.
- R11: After reset, `sync_ok`, `out_valid` and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | Strobe for one received line bit |
| rx_bit | input | 1 | Received serial data bit |
| ext_sync | input | 1 | External alignment pulse, used in external mode |
| cfg_mode | input | 2 | 0 single-SYN, 1 double-SYN, 2/3 external |
| cfg_syn | input | 8 | SYN character pattern |
| cfg_crc_sel | input | 1 | 0: 0x8005, 1: 0x1021 |
| cfg_crc_ones | input | 1 | CRC starting value all ones when 1 |
| cmd_hunt | input | 1 | Return to hunt mode and reload the CRC |
| out_valid | output | 1 | Output character available |
| out_ready | input | 1 | Consumer accepts the character |
| out_data | output | 8 | Received character |
| sync_ok | output | 1 | Character alignment held |
| overrun | output | 1 | Sticky: a character was lost |
| crc_err | output | 1 | CRC register is not zero |

## Verification
The assertions assume that `cfg_syn`, `cfg_mode` and the CRC selections stay constant while characters flow. They also assume that the configuration is changed only together with a `cmd_hunt` pulse. The bench meets this by setting the configuration first and then pulsing `cmd_hunt` at the start of each scenario. Before hunting, it sends idle all-ones bits so that the hunt window holds no stale pattern. The data and CRC bytes are chosen so that none of them equals the SYN value, and a SYN-valued CRC byte is avoided by adjusting the payload.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  localparam int CHAR_W = 8;
  localparam int CRC_W  = 16;
  localparam logic [CRC_W-1:0] POLY_A = 16'h8005;
  localparam logic [CRC_W-1:0] POLY_B = 16'h1021;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_SYN1 = 2'd1,
    ST_SYNC = 2'd2
  } rx_state_t;

  function automatic logic [CRC_W-1:0] crc_char(
    input logic [CRC_W-1:0]  crc_in,
    input logic [CHAR_W-1:0] ch,
    input logic [CRC_W-1:0]  poly
  );
    logic [CRC_W-1:0] c;
    logic fb;
    c = crc_in;
    for (int i = CHAR_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ ch[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction
endpackage

// File: rtl/bsr_align.sv
module bsr_align
  import bsr_pkg::*;
#(
  parameter int CW = CHAR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          rx_bit,
  input  logic          ext_sync,
  input  logic [1:0]    cfg_mode,
  input  logic [CW-1:0] cfg_syn,
  input  logic          cmd_hunt,
  output logic          sync_ok,
  output logic          char_stb,
  output logic [CW-1:0] char_data
);
  localparam int CNT_W = $clog2(CW);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CW - 1);

  rx_state_t        state;
  logic [CW-1:0]    shreg;
  logic [CNT_W-1:0] cnt;
  logic [CW-1:0]    win;
  logic             is_ext;
  logic             is_dbl;

  assign win     = {shreg[CW-2:0], rx_bit};
  assign is_ext  = cfg_mode[1];
  assign is_dbl  = (cfg_mode == 2'd1);
  assign sync_ok = (state == ST_SYNC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_HUNT;
      shreg     <= '1;
      cnt       <= '0;
      char_stb  <= 1'b0;
      char_data <= '0;
    end else begin
      char_stb <= 1'b0;
      if (cmd_hunt) begin
        state <= ST_HUNT;
        cnt   <= '0;
      end else if (bit_en) begin
        shreg <= win;
        unique case (state)
          ST_HUNT: begin
            cnt <= '0;
            if (is_ext) begin
              if (ext_sync) state <= ST_SYNC;
            end else if (win == cfg_syn) begin
              state <= is_dbl ? ST_SYN1 : ST_SYNC;
            end
          end
          ST_SYN1: begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
              cnt   <= '0;
              state <= (win == cfg_syn) ? ST_SYNC : ST_HUNT;
            end
          end
          ST_SYNC: begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
              cnt <= '0;
              if (win != cfg_syn) begin
                char_stb  <= 1'b1;
                char_data <= win;
              end
            end
          end
          default: state <= ST_HUNT;
        endcase
      end
    end
  end

  a_r1_align_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_ok) |-> $past(bit_en));
  a_r10_hunt_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hunt |=> !sync_ok);
  a_r4_strobe_when_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    char_stb |-> $past(sync_ok) && $past(bit_en));
endmodule

// File: rtl/bsr_crc.sv
module bsr_crc
  import bsr_pkg::*;
#(
  parameter int CW = CHAR_W,
  parameter int RW = CRC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_crc_sel,
  input  logic          cfg_crc_ones,
  input  logic          cmd_hunt,
  input  logic          char_stb,
  input  logic [CW-1:0] char_data,
  output logic          crc_err
);
  logic [RW-1:0] crc_q;
  logic [RW-1:0] init_vec;
  logic [RW-1:0] poly;

  assign init_vec = cfg_crc_ones ? '1 : '0;
  assign poly     = cfg_crc_sel ? POLY_B : POLY_A;
  assign crc_err  = |crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || cmd_hunt) crc_q <= init_vec;
    else if (char_stb)      crc_q <= crc_char(crc_q, char_data, poly);
  end

  a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hunt |=> crc_q == $past(init_vec));
  a_r5_crc_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !char_stb && !cmd_hunt |=> $stable(crc_q));
endmodule

// File: rtl/bsr_outreg.sv
module bsr_outreg
  import bsr_pkg::*;
#(
  parameter int CW = CHAR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_hunt,
  input  logic          char_stb,
  input  logic [CW-1:0] char_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [CW-1:0] out_data,
  output logic          overrun
);
  logic stalled;
  assign stalled = out_valid && !out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      overrun   <= 1'b0;
    end else begin
      if (cmd_hunt) overrun <= 1'b0;
      if (char_stb) begin
        if (stalled) begin
          if (!cmd_hunt) overrun <= 1'b1;
        end else begin
          out_valid <= 1'b1;
          out_data  <= char_data;
        end
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |=> out_valid && $stable(out_data));
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !cmd_hunt |=> overrun);
  a_r7_raise: assert property (@(posedge clk) disable iff (!rst_n)
    char_stb && stalled && !cmd_hunt |=> overrun);
endmodule

// File: rtl/bsync_rx.sv
module bsync_rx
  import bsr_pkg::*;
#(
  parameter int CW = CHAR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          rx_bit,
  input  logic          ext_sync,
  input  logic [1:0]    cfg_mode,
  input  logic [CW-1:0] cfg_syn,
  input  logic          cfg_crc_sel,
  input  logic          cfg_crc_ones,
  input  logic          cmd_hunt,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [CW-1:0] out_data,
  output logic          sync_ok,
  output logic          overrun,
  output logic          crc_err
);
  logic          char_stb;
  logic [CW-1:0] char_data;

  bsr_align #(.CW(CW)) u_align (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .ext_sync(ext_sync), .cfg_mode(cfg_mode), .cfg_syn(cfg_syn),
    .cmd_hunt(cmd_hunt), .sync_ok(sync_ok),
    .char_stb(char_stb), .char_data(char_data)
  );

  bsr_crc #(.CW(CW)) u_crc (
    .clk(clk), .rst_n(rst_n), .cfg_crc_sel(cfg_crc_sel),
    .cfg_crc_ones(cfg_crc_ones), .cmd_hunt(cmd_hunt),
    .char_stb(char_stb), .char_data(char_data), .crc_err(crc_err)
  );

  bsr_outreg #(.CW(CW)) u_out (
    .clk(clk), .rst_n(rst_n), .cmd_hunt(cmd_hunt),
    .char_stb(char_stb), .char_data(char_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .overrun(overrun)
  );

  a_r5_no_syn_out: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_data != cfg_syn);
  a_r11_reset: assert property (@(posedge clk)
    !rst_n |=> !out_valid && !overrun && !sync_ok);
endmodule

// File: tb/bsync_rx_bench.sv
module bsync_rx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, rx_bit = 1'b1, ext_sync = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic [7:0] cfg_syn = 8'h16;
  logic cfg_crc_sel = 1'b0, cfg_crc_ones = 1'b0, cmd_hunt = 1'b0;
  logic out_valid, out_ready = 1'b1, sync_ok, overrun, crc_err;
  logic [7:0] out_data;

  int checks = 0;
  int fails = 0;
  logic [7:0] got [0:63];
  int got_n = 0;

  always #5 clk = ~clk;

  bsync_rx u_bsync_rx (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .ext_sync(ext_sync), .cfg_mode(cfg_mode), .cfg_syn(cfg_syn),
    .cfg_crc_sel(cfg_crc_sel), .cfg_crc_ones(cfg_crc_ones),
    .cmd_hunt(cmd_hunt), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .sync_ok(sync_ok), .overrun(overrun),
    .crc_err(crc_err)
  );

  always @(negedge clk)
    if (rst_n && out_valid && out_ready && got_n < 64) begin
      got[got_n] = out_data;
      got_n++;
    end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d, input logic sel);
    logic [15:0] r;
    logic [15:0] p;
    r = c;
    p = sel ? 16'h1021 : 16'h8005;
    for (int k = 7; k >= 0; k--) begin
      if (r[15] ^ d[k]) r = (r << 1) ^ p;
      else r = r << 1;
    end
    return r;
  endfunction

  task automatic send_bit(input logic b, input logic es);
    @(negedge clk);
    rx_bit = b; ext_sync = es; bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0; ext_sync = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int k = 7; k >= 0; k--) send_bit(v[k], 1'b0);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic restart(input logic [1:0] m, input logic sel, input logic ones);
    @(negedge clk);
    cfg_mode = m; cfg_crc_sel = sel; cfg_crc_ones = ones; cmd_hunt = 1'b1;
    @(negedge clk);
    cmd_hunt = 1'b0;
    send_byte(8'hFF);
    settle();
    got_n = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 sync_ok", sync_ok, 0);
    chk("R11 out_valid", out_valid, 0);
    chk("R11 overrun", overrun, 0);
    chk("R9 crc zero start", crc_err, 0);
  endtask

  task automatic t_mono();
    restart(2'd0, 1'b0, 1'b0);
    send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b1); send_bit(1'b1, 1'b0);
    chk("R1 not yet aligned", sync_ok, 0);
    send_byte(8'h16);
    @(negedge clk);
    chk("R1 aligned after SYN", sync_ok, 1);
    send_byte(8'hA5); send_byte(8'h16); send_byte(8'h3C);
    settle();
    chk("R5 fill deleted count", got_n, 2);
    chk("R4 first char", got[0], 8'hA5);
    chk("R4 second char", got[1], 8'h3C);
  endtask

  task automatic t_bisync();
    restart(2'd1, 1'b0, 1'b0);
    send_byte(8'h16); send_byte(8'h55); send_byte(8'hFF);
    settle();
    chk("R2 single SYN no align", sync_ok, 0);
    chk("R2 nothing out", got_n, 0);
    send_byte(8'h16); send_byte(8'h16);
    @(negedge clk);
    chk("R2 aligned after two SYN", sync_ok, 1);
    send_byte(8'h81);
    settle();
    chk("R2 char count", got_n, 1);
    chk("R2 char value", got[0], 8'h81);
  endtask

  task automatic t_ext();
    restart(2'd2, 1'b0, 1'b0);
    send_byte(8'h16);
    chk("R3 SYN ignored in external mode", sync_ok, 0);
    send_bit(1'b0, 1'b1);
    @(negedge clk);
    chk("R3 aligned by pulse", sync_ok, 1);
    send_byte(8'h16); send_byte(8'h6E);
    settle();
    chk("R3 count", got_n, 1);
    chk("R3 first char", got[0], 8'h6E);
  endtask

  task automatic t_crc(input logic sel, input logic ones, input logic corrupt);
    logic [15:0] c;
    logic [7:0] d1;
    logic [7:0] lo;
    restart(2'd0, sel, ones);
    chk("R9 start value", crc_err, ones);
    d1 = 8'h32;
    for (int a = 0; a < 20; a++) begin
      c = ref_crc(ones ? 16'hFFFF : 16'h0000, 8'h31, sel);
      c = ref_crc(c, d1, sel);
      c = ref_crc(c, 8'h33, sel);
      if (c[15:8] != 8'h16 && c[7:0] != 8'h16 &&
          (c[7:0] ^ 8'h01) != 8'h16) break;
      d1 = d1 + 8'h01;
    end
    lo = corrupt ? (c[7:0] ^ 8'h01) : c[7:0];
    send_byte(8'h16);
    send_byte(8'h31); send_byte(d1); send_byte(8'h16);
    send_byte(8'h33); send_byte(c[15:8]); send_byte(lo);
    settle();
    chk("R5 crc frame count", got_n, 5);
    chk("R8 crc residue", crc_err, corrupt);
  endtask

  task automatic t_overrun();
    restart(2'd0, 1'b0, 1'b0);
    out_ready = 1'b0;
    send_byte(8'h16); send_byte(8'h41); send_byte(8'h42);
    settle();
    chk("R6 held valid", out_valid, 1);
    chk("R6 held data", out_data, 8'h41);
    chk("R7 overrun set", overrun, 1);
    @(negedge clk);
    out_ready = 1'b1;
    settle();
    chk("R7 dropped char", got_n, 1);
    chk("R7 overrun sticky", overrun, 1);
    @(negedge clk);
    cfg_crc_ones = 1'b1; cmd_hunt = 1'b1;
    @(negedge clk);
    cmd_hunt = 1'b0;
    chk("R10 hunt clears sync", sync_ok, 0);
    chk("R10 hunt clears overrun", overrun, 0);
    chk("R10 crc reloaded ones", crc_err, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_mono();
    t_bisync();
    t_ext();
    t_crc(1'b0, 1'b0, 1'b0);
    t_crc(1'b1, 1'b1, 1'b0);
    t_crc(1'b1, 1'b0, 1'b1);
    t_overrun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule